// File: doc/BRIEF.md
# Mark-Space Envelope Modulator

This block shapes the on/off envelope of an infrared-style transmitter. Each modulation cycle consists of a mark phase, during which a carrier input is passed to the output (or a constant high level in baseband mode), followed by a space phase, during which the output is held low. Mark and space lengths are counted in prescaled ticks of the block clock.

Software loads the mark and space lengths as pairs of byte registers. These are buffers: at the start of every cycle they are copied into a working counter and a working space register, so the next lengths can be written while the current cycle is still running. A status flag reports each cycle end and can raise an interrupt. The flag clears after a status read that saw it set, followed by any access to the low byte of either length buffer, or on a single-cycle acknowledge pulse from a transfer engine.

The register port is a plain synchronous strobe with combinational read data. Register map: address 0 control/status, 1 mark high byte, 2 mark low byte, 3 space high byte, 4 space low byte; other addresses read as zero.

Top module: `irm_envelope`

## Requirements
- R1: Control bits 6:5 pick the tick rate: codes 00, 01, 10, 11 give one tick every 1, 2, 4, 8 clocks. The field is not buffered. A mark of M ticks with code 10 lasts 4*M clocks.
- R2: Writing control bit 0 as 1 while idle sets the status flag on that edge, and the mark phase drives the output from the next clock on.
- R3: In the mark phase the output equals carrier_in, or 1 when control bit 3 (baseband) is set. It lasts M ticks, where M = {reg1, reg2}; M = 0 skips the mark. In the space phase the output is 0 for S ticks, where S = {reg3, reg4}; S = 0 behaves as S = 1. While idle the output is 0.
- R4: At each cycle end the working mark count and space length are reloaded from the buffers. Writes made during a cycle take effect from the next cycle.
- R5: The flag, read as bit 7 of address 0, is set at every cycle end and stays set until cleared.
- R6: A read of address 0 that returns flag 1 arms the clear. A later access, read or write, to address 2 or 4 then clears the flag. A dma_ack pulse also clears it. A flag set on the same edge wins over a clear.
- R7: Any write to address 0 disarms a pending clear.
- R8: Control bits 6:0 read back as written. Bit 7 is read-only. All registers reset to 0.
- R9: irq_out is the flag ANDed with control bit 1.
- R10: Writing control bit 0 as 0 during a transmission drives the output to 0 from the next clock and returns the block to idle. The flag keeps its value.
- R11: With control bit 4 set, each new cycle skips its mark phase. Cycles still end, reload and set the flag.
- R12: Writing control bit 0 as 1 while a transmission runs does not restart the cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| carrier_in | input | 1 | Carrier to gate during mark |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| dma_ack | input | 1 | Transfer acknowledge, clears the flag |
| mod_out | output | 1 | Modulated envelope |
| irq_out | output | 1 | End-of-cycle interrupt |

## Verification
Directed runs use baseband mode and count high clocks, which separates the tick rates, the reload at a cycle boundary, extended space and the rule that a running cycle is not restarted. Randomized runs use short random mark and space lengths, including zero, together with random carrier bits, status reads, low-byte accesses, acknowledge pulses and control rewrites. A per-clock model of the output, interrupt and read data checks these runs, so an edge that is off by one or a mis-timed reload shows up as a mismatch. Arming sequences with and without an intervening control write separate a correct clear from one that fires too early.

// File: rtl/irm_pkg.sv
// Package: shared state encoding, register addresses and control bit positions
// for the mark-space envelope modulator.
package irm_pkg;

    typedef enum logic [1:0] {
        ENV_IDLE  = 2'd0,
        ENV_MARK  = 2'd1,
        ENV_SPACE = 2'd2
    } env_state_e;

    // register addresses
    localparam int RA_CTRL     = 0;
    localparam int RA_MARK_HI  = 1;
    localparam int RA_MARK_LO  = 2;
    localparam int RA_SPACE_HI = 3;
    localparam int RA_SPACE_LO = 4;

    // control register bit positions
    localparam int CB_EN    = 0;
    localparam int CB_IE    = 1;
    localparam int CB_FSK   = 2;
    localparam int CB_BASE  = 3;
    localparam int CB_EXSP  = 4;
    localparam int CB_DIV_L = 5;
    localparam int CB_DIV_H = 6;

endpackage

// File: rtl/irm_prescaler.sv
// Module: irm_prescaler
// Produces a one-clock tick every 2**sel clocks while the modulator is busy.
// Assumes sel is held constant during a transmission; the counter is held at
// zero while idle, so the first tick comes 2**sel clocks after start.
module irm_prescaler #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int PRE_W = (1 << SEL_W) - 1;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;

    // low bits of the counter that must all be one for a tick
    for (genvar gi = 0; gi < PRE_W; gi++) begin : g_mask
        assign mask[gi] = (sel > SEL_W'(gi));
    end

    // free-running divide counter, cleared while idle
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) pre_q <= '0;
        else                 pre_q <= pre_q + 1'b1;
    end

    assign tick = busy && ((pre_q & mask) == mask);

    // R1: with division above one, ticks are never back to back
    p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && sel != '0) |=> (!tick || sel != $past(sel)));

endmodule

// File: rtl/irm_regs.sv
// Module: irm_regs
// Register file: control bits, double-buffer byte registers for mark and space
// lengths, the end-of-cycle flag and its read-then-access clear sequence.
// Assumes single-cycle bus strobes; read data is combinational.
module irm_regs import irm_pkg::*; #(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_en,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic                dma_ack,
    input  logic                busy,
    input  logic                cyc_end,
    output logic                go,
    output logic                en_nx,
    output logic                exsp_nx,
    output logic                base_en,
    output logic [1:0]          div_sel,
    output logic [2*DATA_W-1:0] mark_buf,
    output logic [2*DATA_W-1:0] space_buf,
    output logic                flag,
    output logic                irq
);
    logic [DATA_W-2:0] ctrl_q;
    logic [DATA_W-1:0] mhi_q, mlo_q, shi_q, slo_q;
    logic              flag_q, armed_q;
    logic              wr, wr_ctrl, rd_stat, lo_acc, set_f, clr_f;

    assign wr      = bus_en && bus_we;
    assign wr_ctrl = wr && (bus_addr == ADDR_W'(RA_CTRL));
    assign rd_stat = bus_en && !bus_we && (bus_addr == ADDR_W'(RA_CTRL));
    assign lo_acc  = bus_en && ((bus_addr == ADDR_W'(RA_MARK_LO)) ||
                                (bus_addr == ADDR_W'(RA_SPACE_LO)));

    assign en_nx   = wr_ctrl ? bus_wdata[CB_EN]   : ctrl_q[CB_EN];
    assign exsp_nx = wr_ctrl ? bus_wdata[CB_EXSP] : ctrl_q[CB_EXSP];
    assign go      = wr_ctrl && bus_wdata[CB_EN] && !busy;
    assign set_f   = go || cyc_end;
    assign clr_f   = dma_ack || (armed_q && lo_acc);

    assign base_en   = ctrl_q[CB_BASE];
    assign div_sel   = ctrl_q[CB_DIV_H:CB_DIV_L];
    assign mark_buf  = {mhi_q, mlo_q};
    assign space_buf = {shi_q, slo_q};
    assign flag      = flag_q;
    assign irq       = flag_q && ctrl_q[CB_IE];

    // software writes to control and buffer registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            mhi_q  <= '0;
            mlo_q  <= '0;
            shi_q  <= '0;
            slo_q  <= '0;
        end else if (wr) begin
            case (bus_addr)
                ADDR_W'(RA_CTRL):     ctrl_q <= bus_wdata[DATA_W-2:0];
                ADDR_W'(RA_MARK_HI):  mhi_q  <= bus_wdata;
                ADDR_W'(RA_MARK_LO):  mlo_q  <= bus_wdata;
                ADDR_W'(RA_SPACE_HI): shi_q  <= bus_wdata;
                ADDR_W'(RA_SPACE_LO): slo_q  <= bus_wdata;
                default: ;
            endcase
        end
    end

    // end-of-cycle flag: set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_q <= 1'b0;
        else if (set_f) flag_q <= 1'b1;
        else if (clr_f) flag_q <= 1'b0;
    end

    // arming of the read-then-access clear sequence
    always_ff @(posedge clk) begin
        if (!rst_n)                  armed_q <= 1'b0;
        else if (wr_ctrl)            armed_q <= 1'b0;
        else if (clr_f)              armed_q <= 1'b0;
        else if (rd_stat && flag_q)  armed_q <= 1'b1;
    end

    // combinational read mux
    always_comb begin
        case (bus_addr)
            ADDR_W'(RA_CTRL):     bus_rdata = {flag_q, ctrl_q};
            ADDR_W'(RA_MARK_HI):  bus_rdata = mhi_q;
            ADDR_W'(RA_MARK_LO):  bus_rdata = mlo_q;
            ADDR_W'(RA_SPACE_HI): bus_rdata = shi_q;
            ADDR_W'(RA_SPACE_LO): bus_rdata = slo_q;
            default:              bus_rdata = '0;
        endcase
    end

    p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_end |=> flag_q);
    p_start_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> flag_q);
    p_dma_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_ack && !cyc_end && !go) |=> !flag_q);
    p_disarm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> !armed_q);

endmodule

// File: rtl/irm_engine.sv
// Module: irm_engine
// Mark/space sequencer. Loads the working count and space length from the
// buffers at start and at every cycle end; counts mark down to zero, then
// counts space up until it reaches the working space length.
// Assumes go only arrives while idle.
module irm_engine import irm_pkg::*; #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             go,
    input  logic             en_nx,
    input  logic             exsp_nx,
    input  logic [CNT_W-1:0] mark_buf,
    input  logic [CNT_W-1:0] space_buf,
    output logic             busy,
    output logic             in_mark,
    output logic             cyc_end
);
    env_state_e       st_q;
    logic [CNT_W-1:0] cnt_q, space_q;
    logic             space_hit;

    assign busy      = (st_q != ENV_IDLE);
    assign in_mark   = (st_q == ENV_MARK);
    assign space_hit = ({1'b0, cnt_q} + (CNT_W+1)'(1)) >= {1'b0, space_q};
    assign cyc_end   = (st_q == ENV_SPACE) && tick && en_nx && space_hit;

    // phase sequencing, counter and working space register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ENV_IDLE;
            cnt_q   <= '0;
            space_q <= '0;
        end else if (go || cyc_end) begin
            space_q <= space_buf;
            if (exsp_nx || mark_buf == '0) begin
                st_q  <= ENV_SPACE;
                cnt_q <= '0;
            end else begin
                st_q  <= ENV_MARK;
                cnt_q <= mark_buf;
            end
        end else if (!en_nx) begin
            st_q <= ENV_IDLE;
        end else if (tick) begin
            if (st_q == ENV_MARK) begin
                if (cnt_q <= CNT_W'(1)) begin
                    st_q  <= ENV_SPACE;
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end else if (st_q == ENV_SPACE) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    p_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !en_nx) |=> (st_q == ENV_IDLE));
    p_exspace_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((go || cyc_end) && exsp_nx) |=> (st_q == ENV_SPACE));
    p_no_restart_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ENV_SPACE && en_nx && !cyc_end) |=> (st_q != ENV_MARK));

endmodule

// File: rtl/irm_envelope.sv
// Module: irm_envelope (top)
// Mark-space envelope modulator: register file, tick prescaler and mark/space
// sequencer; gates the carrier (or a constant 1 in baseband) during mark.
// Assumes carrier_in is synchronous to clk.
module irm_envelope import irm_pkg::*; #(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              carrier_in,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              dma_ack,
    output logic              mod_out,
    output logic              irq_out
);
    localparam int CNT_W = 2 * DATA_W;

    logic             go, en_nx, exsp_nx, base_en, flag, busy, in_mark, cyc_end, tick;
    logic [1:0]       div_sel;
    logic [CNT_W-1:0] mark_buf, space_buf;

    irm_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dma_ack(dma_ack), .busy(busy), .cyc_end(cyc_end), .go(go),
        .en_nx(en_nx), .exsp_nx(exsp_nx), .base_en(base_en), .div_sel(div_sel),
        .mark_buf(mark_buf), .space_buf(space_buf), .flag(flag), .irq(irq_out)
    );

    irm_prescaler #(.SEL_W(2)) pre_i (
        .clk(clk), .rst_n(rst_n), .busy(busy), .sel(div_sel), .tick(tick)
    );

    irm_engine #(.CNT_W(CNT_W)) eng_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .go(go), .en_nx(en_nx),
        .exsp_nx(exsp_nx), .mark_buf(mark_buf), .space_buf(space_buf),
        .busy(busy), .in_mark(in_mark), .cyc_end(cyc_end)
    );

    // output gating: carrier or constant high in mark, low otherwise
    assign mod_out = in_mark && (base_en || carrier_in);

    // R9: interrupt only ever raised with a set flag
    p_irq_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> flag);
    // R3: output is low whenever the sequencer is idle
    p_idle_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mod_out);

endmodule

// File: tb/irm_envelope_tb_top.sv
// Bench for irm_envelope: directed corner cases plus seeded random bus traffic,
// all outputs compared every clock against a requirement-level cycle model.
module irm_envelope_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       carrier_in = 1'b0;
    logic       bus_en = 1'b0, bus_we = 1'b0, dma_ack = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       mod_out, irq_out;

    always #10 clk = ~clk; // 20 time units per period: 50 MHz at 1 ns units

    irm_envelope dut_i (
        .clk(clk), .rst_n(rst_n), .carrier_in(carrier_in), .bus_en(bus_en),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .dma_ack(dma_ack), .mod_out(mod_out), .irq_out(irq_out)
    );

    int n_run = 0, n_fail = 0, hi_cnt = 0;
    bit done = 1'b0;
    logic [7:0] last_rd;

    // model state
    bit         m_busy, m_skip, m_flag, m_armed;
    int         m_pos, m_M, m_S;
    logic [6:0] m_ctrl;
    logic [7:0] m_buf [1:4];

    function automatic int div_of(logic [1:0] s);
        return 1 << s;
    endfunction

    function automatic int cyc_len();
        int mk = m_skip ? 0 : m_M;
        int sp = (m_S == 0) ? 1 : m_S;
        return (mk + sp) * div_of(m_ctrl[6:5]);
    endfunction

    function automatic logic [7:0] exp_rd(logic [2:0] a);
        if (a == 3'd0) return {m_flag, m_ctrl};
        if (a >= 3'd1 && a <= 3'd4) return m_buf[a];
        return 8'h00;
    endfunction

    task automatic check(string tag, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // one clock: drive inputs, check outputs, advance the model over the edge
    task automatic cyc(bit en, bit we, logic [2:0] a, logic [7:0] d, bit dma);
        bit wr_c, rd_s, lo, setf, clr, mk;
        int L;
        bus_en = en; bus_we = we; bus_addr = a; bus_wdata = d; dma_ack = dma;
        carrier_in = 1'($urandom);
        #1;
        mk = m_busy && !m_skip && (m_pos < m_M * div_of(m_ctrl[6:5]));
        check("R3", mod_out, mk ? (m_ctrl[3] ? 1 : int'(carrier_in)) : 0);
        check("R9", irq_out, m_flag && m_ctrl[1]);
        if (en && !we) begin
            check("R8", bus_rdata, exp_rd(a));
            last_rd = bus_rdata;
        end
        if (mod_out) hi_cnt++;
        wr_c = en && we && a == 3'd0;
        rd_s = en && !we && a == 3'd0;
        lo   = en && (a == 3'd2 || a == 3'd4);
        setf = 1'b0;
        L = cyc_len();
        if (wr_c && d[0] && !m_busy) begin
            m_busy = 1; m_pos = 0; m_skip = d[4]; setf = 1;
            m_M = {m_buf[1], m_buf[2]}; m_S = {m_buf[3], m_buf[4]};
        end else if (m_busy) begin
            if (wr_c && !d[0]) m_busy = 0;
            else begin
                m_pos++;
                if (m_pos >= L) begin
                    m_pos = 0; setf = 1;
                    m_M = {m_buf[1], m_buf[2]}; m_S = {m_buf[3], m_buf[4]};
                    m_skip = wr_c ? d[4] : m_ctrl[4];
                end
            end
        end
        clr = dma || (m_armed && lo);
        if (wr_c) m_armed = 0;
        else if (clr) m_armed = 0;
        else if (rd_s && m_flag) m_armed = 1;
        if (setf) m_flag = 1; else if (clr) m_flag = 0;
        if (en && we) begin
            if (a == 3'd0) m_ctrl = d[6:0];
            else if (a <= 3'd4) m_buf[a] = d;
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 3'd0, 8'h00, 0);
    endtask
    task automatic wr(logic [2:0] a, logic [7:0] d);
        cyc(1, 1, a, d, 0);
    endtask
    task automatic rd(logic [2:0] a);
        cyc(1, 0, a, 8'h00, 0);
    endtask
    task automatic set_len(int mk, int sp);
        wr(3'd1, 8'(mk >> 8)); wr(3'd2, 8'(mk));
        wr(3'd3, 8'(sp >> 8)); wr(3'd4, 8'(sp));
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        m_busy = 0; m_skip = 0; m_flag = 0; m_armed = 0; m_pos = 0; m_M = 0; m_S = 0;
        m_ctrl = '0;
        for (int i = 1; i <= 4; i++) m_buf[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R8: reset state
        rd(3'd0); check("R8", last_rd, 0);
        check("R8", irq_out, 0);

        // R1: divide by 4, mark 2 ticks, space 1 tick, baseband
        set_len(2, 1);
        wr(3'd0, 8'h49);
        hi_cnt = 0; idle(12);
        check("R1", hi_cnt, 8);
        rd(3'd0); check("R2", last_rd[7], 1);

        // R10: stop keeps flag, output low
        wr(3'd0, 8'h48);
        idle(3); check("R10", mod_out, 0);
        rd(3'd0); check("R10", last_rd[7], 1);

        // R6: long cycle, read-then-access clear
        set_len(100, 100);
        wr(3'd0, 8'h0B);
        rd(3'd0); rd(3'd2); rd(3'd0); check("R6", last_rd[7], 0);
        idle(200); rd(3'd0); check("R5", last_rd[7], 1);
        cyc(0, 0, 3'd0, 8'h00, 1); rd(3'd0); check("R6", last_rd[7], 0);

        // R7: control write between the read and the access
        idle(200); rd(3'd0); wr(3'd0, 8'h0B); rd(3'd4);
        rd(3'd0); check("R7", last_rd[7], 1);

        // R4: new lengths written mid-cycle apply at the next cycle
        wr(3'd0, 8'h08); set_len(100, 100); wr(3'd0, 8'h09);
        set_len(5, 5); idle(196);
        hi_cnt = 0; idle(10); check("R4", hi_cnt, 5);

        // R12: re-enable during space does not restart
        wr(3'd0, 8'h08); set_len(4, 4); wr(3'd0, 8'h09);
        idle(5); wr(3'd0, 8'h09); check("R12", mod_out, 0);

        // R11: extended space skips mark, cycles still end
        wr(3'd0, 8'h08); set_len(5, 5); wr(3'd0, 8'h19);
        rd(3'd0); rd(3'd2);
        hi_cnt = 0; idle(12);
        check("R11", hi_cnt, 0);
        rd(3'd0); check("R11", last_rd[7], 1);

        // random phases
        for (int run = 0; run < 10; run++) begin
            logic [1:0] sel = 2'($urandom);
            wr(3'd0, {1'b0, sel, 5'b0});
            set_len($urandom % 7, $urandom % 7);
            wr(3'd0, {1'b0, sel, 4'($urandom), 1'b1});
            for (int k = 0; k < 300; k++) begin
                int r = $urandom % 16;
                case (r)
                    0: rd(3'd0);
                    1: rd(($urandom % 2) ? 3'd2 : 3'd4);
                    2: wr(($urandom % 2) ? 3'd2 : 3'd4, 8'($urandom % 7));
                    3: cyc(0, 0, 3'd0, 8'h00, 1);
                    4: wr(3'd0, {1'b0, sel, 4'($urandom), 1'b1});
                    5: rd(3'($urandom));
                    6: if ($urandom % 4 == 0) wr(3'd0, {1'b0, sel, 4'($urandom), 1'b0});
                       else idle(1);
                    default: idle(1);
                endcase
            end
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule